// File: doc/BRIEF.md
# Bi-endian Load/Store Alignment Unit

This unit sits between a processor core and a 32-bit word-addressed data memory. For each request it receives an effective byte address, an access size (byte, halfword or word), a signedness flag and, for stores, the source register value. It turns a store into a word-aligned memory write with a byte-enable mask and write data placed on the right byte lanes. It turns a load into a word-aligned memory read, then pulls the addressed bytes out of the returned word and sign- or zero-extends them to 32 bits.

Byte ordering is chosen at run time. A default-endianness input is combined with a reverse-endian control bit, and the result decides whether the most or the least significant byte of a multi-byte value lives at the lowest address. Accesses that break the natural alignment of their size are not split. They are dropped before they reach memory, and an exception report carries the faulting address and the access direction.

The memory is assumed to return read data exactly one cycle after an accepted read request. The load result leaves the unit one cycle after that.

Top module: `lsa_align_unit`

## Requirements
- R1: Size code 0 is a byte, 1 a halfword, 2 and 3 a word. Memory byte lane k (bits 8k+7..8k, enable bit k) holds the byte at address 4*W+k of word W. An accepted access drives `mem_addr_o` with address bits 1:0 cleared. It enables lane a[1:0] for a byte, lanes a[1:0] and a[1:0]+1 for a halfword, and all four lanes for a word.
- R2: A halfword at an odd address and a word whose address bits 1:0 are not 00 are misaligned. A byte is never misaligned.
- R3: A misaligned valid request sends no memory request and drives all byte enables to zero. In the next cycle `exc_valid_o` is 1, `exc_addr_o` holds the request address and `exc_store_o` holds its store flag. In all other cycles `exc_valid_o` is 0.
- R4: The active ordering is big-endian when `big_endian_i` XOR `endian_flip_i` is 1, and little-endian otherwise.
- R5: A store writes the low 1, 2 or 4 bytes of `req_wdata_i`. In little-endian order the least significant byte goes to the lowest address; in big-endian order the most significant byte does. `mem_we_o` is 1 only for accepted stores.
- R6: Store data is replicated. For a byte store all four lanes carry the byte, and for a halfword store both 16-bit halves of `mem_wdata_o` are equal.
- R7: A byte or halfword load sign-extends to 32 bits when `req_unsigned_i` is 0 and zero-extends when it is 1.
- R8: A load reassembles the addressed bytes in the active order. `ld_valid_o` pulses for one cycle, two cycles after the accepted request, with the value on `ld_data_o`.
- R9: `ld_data_o` changes only together with `ld_valid_o`. A misaligned load or a store leaves the previous load result unchanged.
- R10: While reset is active and after it is released, `ld_valid_o`, `ld_data_o`, `exc_valid_o`, `exc_addr_o` and `exc_store_o` are zero until a request changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_store_i | input | 1 | 1 for store, 0 for load |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_unsigned_i | input | 1 | Zero-extend a load instead of sign-extending it |
| req_addr_i | input | ADDR_W | Effective byte address |
| req_wdata_i | input | 32 | Store source register value |
| big_endian_i | input | 1 | Default ordering, 1 for big-endian |
| endian_flip_i | input | 1 | Reverse-endian control |
| mem_req_o | output | 1 | Memory access accepted |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Lane-placed write data |
| mem_rdata_i | input | 32 | Read word, one cycle after a read request |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Extended load result |
| exc_valid_o | output | 1 | Alignment exception |
| exc_addr_o | output | ADDR_W | Faulting address |
| exc_store_o | output | 1 | Faulting access was a store |

## Verification
The exception report for one request and the load result for the request before it can appear in the same cycle. Their pipeline depths differ by one stage. The bench provokes this by issuing an aligned load followed at once by a misaligned one. In that cycle it expects the correct extended value with `ld_valid_o` set, together with the exception address and direction. In the next cycle it expects `ld_data_o` unchanged. A behavioural byte-array model, updated by address rather than by lane, predicts every output on every clock. Random traffic mixes both orderings, the flip bit and all sizes and offsets.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } acc_size_e;

  function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < LANES; k++) r[8*k +: 8] = w[8*(LANES-1-k) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/lsa_lane_mask.sv
module lsa_lane_mask
  import lsa_pkg::*;
(
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [LANES-1:0] be_o,
  output logic             misal_o
);
  localparam logic [LANES-1:0] ONE_LANE = LANES'(1);
  localparam logic [LANES-1:0] TWO_LANE = LANES'(3);

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        be_o    = ONE_LANE << off_i;
        misal_o = 1'b0;
      end
      SZ_HALF: begin
        be_o    = TWO_LANE << off_i;
        misal_o = off_i[0];
      end
      default: begin
        be_o    = '1;
        misal_o = (off_i != '0);
      end
    endcase
  end
endmodule

// File: rtl/lsa_store_pack.sv
module lsa_store_pack
  import lsa_pkg::*;
(
  input  acc_size_e         size_i,
  input  logic              big_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] wdata_o
);
  // each lane carries the byte it would hold at any legal offset
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      unique case (size_i)
        SZ_BYTE: wdata_o[8*k +: 8] = src_i[7:0];
        SZ_HALF: begin
          if ((k % 2 == 0) ^ big_i) wdata_o[8*k +: 8] = src_i[7:0];
          else                      wdata_o[8*k +: 8] = src_i[15:8];
        end
        default: begin
          if (big_i) wdata_o[8*k +: 8] = src_i[8*(LANES-1-k) +: 8];
          else       wdata_o[8*k +: 8] = src_i[8*k +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
(
  input  logic [DATA_W-1:0] word_i,
  input  logic [OFF_W-1:0]  off_i,
  input  acc_size_e         size_i,
  input  logic              unsigned_i,
  input  logic              big_i,
  output logic [DATA_W-1:0] data_o
);
  logic [7:0]       lane [LANES];
  logic [OFF_W-1:0] off_nx;
  logic [7:0]       b_sel;
  logic [15:0]      h_sel;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k] = word_i[8*k +: 8];
  end

  assign off_nx = off_i | OFF_W'(1);
  assign b_sel  = lane[off_i];
  assign h_sel  = big_i ? {lane[off_i], lane[off_nx]} : {lane[off_nx], lane[off_i]};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = unsigned_i ? {{(DATA_W-8){1'b0}}, b_sel}
                                   : {{(DATA_W-8){b_sel[7]}}, b_sel};
      SZ_HALF: data_o = unsigned_i ? {{(DATA_W-16){1'b0}}, h_sel}
                                   : {{(DATA_W-16){h_sel[15]}}, h_sel};
      default: data_o = big_i ? swap_bytes(word_i) : word_i;
    endcase
  end
endmodule

// File: rtl/lsa_align_unit.sv
module lsa_align_unit
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_unsigned_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              big_endian_i,
  input  logic              endian_flip_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              ld_valid_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              exc_valid_o,
  output logic [ADDR_W-1:0] exc_addr_o,
  output logic              exc_store_o
);
  acc_size_e        size;
  logic [OFF_W-1:0] off;
  logic             big, misal, accept;
  logic [LANES-1:0] be_raw;
  logic [DATA_W-1:0] ld_ext;

  // response-stage context
  logic             rd_pend_q, rd_uns_q, rd_big_q;
  logic [OFF_W-1:0] rd_off_q;
  acc_size_e        rd_size_q;

  logic              ld_valid_q;
  logic [DATA_W-1:0] ld_data_q;
  logic              exc_valid_q, exc_store_q;
  logic [ADDR_W-1:0] exc_addr_q;

  assign size   = acc_size_e'(req_size_i);
  assign off    = req_addr_i[OFF_W-1:0];
  assign big    = big_endian_i ^ endian_flip_i;
  assign accept = req_valid_i & ~misal;

  lsa_lane_mask u_mask (
    .size_i  (size),
    .off_i   (off),
    .be_o    (be_raw),
    .misal_o (misal)
  );

  lsa_store_pack u_pack (
    .size_i  (size),
    .big_i   (big),
    .src_i   (req_wdata_i),
    .wdata_o (mem_wdata_o)
  );

  lsa_load_extract u_extract (
    .word_i     (mem_rdata_i),
    .off_i      (rd_off_q),
    .size_i     (rd_size_q),
    .unsigned_i (rd_uns_q),
    .big_i      (rd_big_q),
    .data_o     (ld_ext)
  );

  assign mem_req_o  = accept;
  assign mem_we_o   = accept & req_store_i;
  assign mem_addr_o = {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_be_o   = accept ? be_raw : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      rd_uns_q  <= 1'b0;
      rd_big_q  <= 1'b0;
      rd_off_q  <= '0;
      rd_size_q <= SZ_BYTE;
    end else begin
      rd_pend_q <= accept & ~req_store_i;
      if (accept & ~req_store_i) begin
        rd_uns_q  <= req_unsigned_i;
        rd_big_q  <= big;
        rd_off_q  <= off;
        rd_size_q <= size;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_q <= 1'b0;
      ld_data_q  <= '0;
    end else begin
      ld_valid_q <= rd_pend_q;
      if (rd_pend_q) ld_data_q <= ld_ext;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_valid_q <= 1'b0;
      exc_addr_q  <= '0;
      exc_store_q <= 1'b0;
    end else begin
      exc_valid_q <= req_valid_i & misal;
      if (req_valid_i & misal) begin
        exc_addr_q  <= req_addr_i;
        exc_store_q <= req_store_i;
      end
    end
  end

  assign ld_valid_o  = ld_valid_q;
  assign ld_data_o   = ld_data_q;
  assign exc_valid_o = exc_valid_q;
  assign exc_addr_o  = exc_addr_q;
  assign exc_store_o = exc_store_q;
endmodule

// File: rtl/lsa_align_checker.sv
module lsa_align_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_store_i,
  input logic [1:0]        req_size_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [3:0]        mem_be_o,
  input logic [31:0]       mem_wdata_o,
  input logic              ld_valid_o,
  input logic [31:0]       ld_data_o,
  input logic              exc_valid_o,
  input logic [ADDR_W-1:0] exc_addr_o,
  input logic              exc_store_o
);
  logic bad;
  assign bad = req_valid_i &&
               (((req_size_i == 2'd1) && req_addr_i[0]) ||
                ((req_size_i[1] == 1'b1) && (req_addr_i[1:0] != 2'b00)));

  assert_be_shape_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (($countones(mem_be_o) == 1) || (mem_be_o == 4'b0011) ||
                   (mem_be_o == 4'b1100) || (mem_be_o == 4'b1111)));

  assert_byte_lane_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i == 2'd0) |->
      (mem_req_o && $countones(mem_be_o) == 1 && mem_be_o[req_addr_i[1:0]]));

  assert_word_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  assert_misalign_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |-> (!mem_req_o && !mem_we_o && mem_be_o == 4'b0000));

  assert_misalign_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> (exc_valid_o && exc_addr_o == $past(req_addr_i) && exc_store_o == $past(req_store_i)));

  assert_aligned_no_exc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad |=> !exc_valid_o);

  assert_half_repl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && req_size_i == 2'd1) |-> (mem_wdata_o[31:16] == mem_wdata_o[15:0]));

  assert_load_return_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> ##1 ld_valid_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_o |-> $stable(ld_data_o));
endmodule

bind lsa_align_unit lsa_align_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_store_i (req_store_i),
  .req_size_i  (req_size_i),
  .req_addr_i  (req_addr_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_be_o    (mem_be_o),
  .mem_wdata_o (mem_wdata_o),
  .ld_valid_o  (ld_valid_o),
  .ld_data_o   (ld_data_o),
  .exc_valid_o (exc_valid_o),
  .exc_addr_o  (exc_addr_o),
  .exc_store_o (exc_store_o)
);

// File: tb/lsa_align_unit_bench.sv
`timescale 1ns/1ps
module lsa_align_unit_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic        req_valid_i = 0, req_store_i = 0, req_unsigned_i = 0;
  logic [1:0]  req_size_i = 0;
  logic [31:0] req_addr_i = 0, req_wdata_i = 0;
  logic        big_endian_i = 0, endian_flip_i = 0;
  logic        mem_req_o, mem_we_o, ld_valid_o, exc_valid_o, exc_store_o;
  logic [31:0] mem_addr_o, mem_wdata_o, ld_data_o, exc_addr_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_rdata_i = 0;

  lsa_align_unit u_lsa_align_unit (.*);

  // memory: lane k of word W is byte 4W+k
  logic [31:0] mem [4];
  always @(posedge clk_i) begin
    if (mem_req_o) begin
      if (mem_we_o) begin
        for (int k = 0; k < 4; k++)
          if (mem_be_o[k]) mem[mem_addr_o[3:2]][8*k +: 8] <= mem_wdata_o[8*k +: 8];
      end else mem_rdata_i <= mem[mem_addr_o[3:2]];
    end
  end

  logic [7:0] rb [16];
  int checks = 0, failures = 0;

  // applied request and model pipeline
  bit          c_v, c_st, c_uns, c_big, c_flip;
  logic [1:0]  c_sz;
  logic [31:0] c_a, c_wd;
  bit          ld1_v;
  logic [31:0] ld1_val, held;
  string       ld1_tag;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit ref_mis(input logic [31:0] a, input logic [1:0] sz);
    int n = nbytes(sz);
    return (a % n) != 0;
  endfunction

  function automatic logic [31:0] ref_load(input logic [31:0] a, input logic [1:0] sz,
                                           input bit uns, input bit bg);
    int n = nbytes(sz);
    logic [31:0] v = 0;
    for (int i = 0; i < n; i++) begin
      int pos = bg ? (n - 1 - i) : i;
      v[8*pos +: 8] = rb[(a + i) & 15];
    end
    if (n == 1 && !uns && v[7])  v[31:8]  = '1;
    if (n == 2 && !uns && v[15]) v[31:16] = '1;
    return v;
  endfunction

  function automatic logic [7:0] src_byte(input logic [31:0] s, input int i, input int n, input bit bg);
    int pos = bg ? (n - 1 - i) : i;
    return s[8*pos +: 8];
  endfunction

  task automatic check_now();
    bit e_mis, e_req, bg;
    int n;
    logic [3:0] e_be;
    string tg;
    e_mis = c_v && ref_mis(c_a, c_sz);
    e_req = c_v && !e_mis;
    bg = c_big ^ c_flip;
    n = nbytes(c_sz);
    e_be = 0;
    for (int i = 0; i < n; i++) e_be[(int'(c_a[1:0]) + i) & 3] = 1'b1;
    tg = e_mis ? "R3" : "R1";
    chk(mem_req_o == e_req, tg, {31'd0, mem_req_o}, {31'd0, e_req});
    chk(mem_we_o == (e_req && c_st), "R5", {31'd0, mem_we_o}, {31'd0, e_req && c_st});
    if (e_req) begin
      chk(mem_addr_o == {c_a[31:2], 2'b00}, "R1", mem_addr_o, {c_a[31:2], 2'b00});
      chk(mem_be_o == e_be, "R1", {28'd0, mem_be_o}, {28'd0, e_be});
      if (c_st) begin
        for (int i = 0; i < n; i++) begin
          int ln = (int'(c_a[1:0]) + i) & 3;
          logic [7:0] eb = src_byte(c_wd, i, n, bg);
          chk(mem_wdata_o[8*ln +: 8] == eb, c_flip ? "R4" : "R5",
              {24'd0, mem_wdata_o[8*ln +: 8]}, {24'd0, eb});
        end
        if (n == 1)
          chk(mem_wdata_o == {4{c_wd[7:0]}}, "R6", mem_wdata_o, {4{c_wd[7:0]}});
        if (n == 2)
          chk(mem_wdata_o[31:16] == mem_wdata_o[15:0], "R6", mem_wdata_o, {2{mem_wdata_o[15:0]}});
      end
    end else
      chk(mem_be_o == 4'b0000, "R3", {28'd0, mem_be_o}, 32'd0);
    // exception for the applied request appears one clock later (now)
    chk(exc_valid_o == e_mis, e_mis ? "R3" : "R2", {31'd0, exc_valid_o}, {31'd0, e_mis});
    if (e_mis) begin
      chk(exc_addr_o == c_a, "R3", exc_addr_o, c_a);
      chk(exc_store_o == c_st, "R3", {31'd0, exc_store_o}, {31'd0, c_st});
    end
    // load result of the request before
    if (ld1_v) held = ld1_val;
    chk(ld_valid_o == ld1_v, "R8", {31'd0, ld_valid_o}, {31'd0, ld1_v});
    chk(ld_data_o == held, ld1_v ? ld1_tag : "R9", ld_data_o, held);
    // advance model
    ld1_v = e_req && !c_st;
    if (ld1_v) begin
      ld1_val = ref_load(c_a, c_sz, c_uns, bg);
      ld1_tag = (n < 4) ? "R7" : (c_flip ? "R4" : "R8");
    end
    if (e_req && c_st)
      for (int i = 0; i < n; i++) rb[(c_a + i) & 15] = src_byte(c_wd, i, n, bg);
  endtask

  task automatic step(input bit v, input bit st, input logic [1:0] sz, input bit uns,
                      input logic [31:0] a, input logic [31:0] wd, input bit bd, input bit fl);
    @(negedge clk_i);
    check_now();
    c_v = v; c_st = st; c_sz = sz; c_uns = uns; c_a = a; c_wd = wd; c_big = bd; c_flip = fl;
    req_valid_i = v; req_store_i = st; req_size_i = sz; req_unsigned_i = uns;
    req_addr_i = a; req_wdata_i = wd; big_endian_i = bd; endian_flip_i = fl;
  endtask

  task automatic idle();
    step(0, 0, 2'd0, 0, 32'd0, 32'd0, 0, 0);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int w = 0; w < 4; w++)
      for (int k = 0; k < 4; k++) begin
        rb[4*w+k] = 8'((4*w+k) * 8'h2B + 8'h11);
        mem[w][8*k +: 8] = rb[4*w+k];
      end
    c_v = 0; c_st = 0; c_sz = 0; c_uns = 0; c_a = 0; c_wd = 0; c_big = 0; c_flip = 0;
    ld1_v = 0; ld1_val = 0; held = 0; ld1_tag = "R8";
    repeat (3) @(negedge clk_i);
    // R10: reset state while held in reset
    chk(ld_valid_o == 0 && exc_valid_o == 0, "R10", {30'd0, ld_valid_o, exc_valid_o}, 32'd0);
    chk(ld_data_o == 0 && exc_addr_o == 0 && exc_store_o == 0, "R10", ld_data_o | exc_addr_o, 32'd0);
    rst_ni = 1'b1;
    idle(); idle();

    // R5/R8: little-endian word then byte reads (78,56,34,12 at 0..3)
    step(1, 1, 2'd2, 0, 32'h0000_0000, 32'h1234_5678, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 2'd0, 1, 32'(i), 0, 0, 0);
    // R5: big-endian word at 4, halfword reads both orderings
    step(1, 1, 2'd2, 0, 32'h0000_0004, 32'h1234_5678, 1, 0);
    step(1, 0, 2'd1, 1, 32'h0000_0004, 0, 1, 0);
    step(1, 0, 2'd1, 1, 32'h0000_0006, 0, 0, 0);
    // R4: flip bit reverses either default
    step(1, 1, 2'd1, 0, 32'h0000_0008, 32'hAAAA_BEEF, 1, 1);
    step(1, 0, 2'd2, 0, 32'h0000_0008, 0, 0, 1);
    step(1, 0, 2'd2, 0, 32'h0000_0008, 0, 0, 0);
    // R7: sign and zero extension
    step(1, 1, 2'd0, 0, 32'h0000_0009, 32'h0000_0080, 0, 0);
    step(1, 0, 2'd0, 0, 32'h0000_0009, 0, 0, 0);
    step(1, 0, 2'd0, 1, 32'h0000_0009, 0, 0, 0);
    step(1, 1, 2'd1, 0, 32'h0000_000E, 32'h0000_9001, 1, 0);
    step(1, 0, 2'd1, 0, 32'h0000_000E, 0, 1, 0);
    step(1, 0, 2'd1, 1, 32'h0000_000E, 0, 1, 0);
    // R3/R9: good load immediately followed by a misaligned load, then hold
    step(1, 0, 2'd2, 0, 32'h0000_0004, 0, 1, 0);
    step(1, 0, 2'd1, 0, 32'h8000_0003, 0, 0, 0);
    idle(); idle();
    // R2/R3: misaligned word store leaves memory untouched
    step(1, 1, 2'd2, 0, 32'h0000_0002, 32'hDEAD_BEEF, 0, 0);
    step(1, 0, 2'd2, 0, 32'h0000_0000, 0, 0, 0);
    // R1: size code 3 behaves as a word
    step(1, 0, 2'd3, 0, 32'h0000_000C, 0, 0, 0);
    step(1, 0, 2'd3, 0, 32'h0000_000D, 0, 0, 0);
    idle(); idle();

    for (int t = 0; t < 1500; t++)
      step(($urandom % 10) < 8, $urandom % 2, 2'($urandom), $urandom % 2,
           $urandom, $urandom, $urandom % 2, $urandom % 2);
    idle(); idle(); idle();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule